// File: doc/BRIEF.md
# Multithreaded Fetch PC Sequencer

This block holds one fetch program counter, one valid flag and one sequence counter for each hardware thread of an in-order pipeline. When a fetch stage asks for the next instruction of a thread, the block answers in the same cycle with the current PC, used both as the instruction PC and as the fetch address, and a sequence number. At the clock edge it advances that PC by one instruction (4 bytes) and bumps the counter. If the thread has no valid PC, the request stalls.

Control-update requests from later stages tell the sequencer what a control instruction predicted. A return that was predicted not-taken has no known target. The thread's PC is then marked invalid, and a one-cycle block pulse goes to the requesting stage. A control instruction predicted taken makes the block emit a squash request naming the thread and the stage. Several squash ports feed redirects back in. Within one cycle, a squash that is no older than one already accepted for the same thread is dropped. An accepted redirect reloads the PC, and it unblocks the recorded stage if the PC was invalid. Activate, trap and deactivate commands load the PC from the architectural PC or retire the thread.

Top module: `fetch_pc_seq`

## Requirements
- R1: An assign request for a thread with a valid PC, and without fault or same-thread squash, sets asg_ok_o to 1 in the same cycle. It returns that thread's PC on asg_pc_o, and the thread's PC is 4 higher from the next cycle.
- R2: Each thread owns a sequence counter, reset to 0. asg_seq_o shows it, and it increments by one only after a successful assign for that thread.
- R3: An assign request for a thread whose PC is invalid gives asg_ok_o = 0. That thread's PC and counter stay unchanged.
- R4: A faulted assign request gives asg_ok_o = 0 and changes no state. A faulted control-update produces no block pulse and no squash request.
- R5: A control-update with is_ctrl=1, is_ret=1 and pred_taken=0 sets bit (tid*NUM_STG + stage) of block_o for exactly the next cycle. It clears the thread's valid flag and records the stage.
- R6: A control-update with is_ctrl=1 and pred_taken=1 raises sqo_vld_o for the next cycle, with sqo_tid_o and sqo_stage_o copied from the request. With is_ctrl=0 the request has no effect.
- R7: Squash port p is dropped when a lower-numbered port, accepted in the same cycle for the same thread, carries a sequence number less than or equal to port p's. Among the accepted ports of one thread, the highest-numbered one sets the final PC.
- R8: An accepted squash with fault=1 clears the thread's valid flag. Otherwise it loads the PC from the target and sets the flag. If the flag was clear, it sets bit (tid*NUM_STG + recorded stage) of unblock_o for the next cycle.
- R9: Deactivate clears the thread's valid flag and resets its recorded stage to 0. It overrides every other command on that thread in the same cycle.
- R10: Activate or trap loads the thread's PC from arch_pc_i and sets its valid flag.
- R11: A squash accepted for the thread of an assign request in the same cycle wins. asg_ok_o is 0 and the counter does not advance.
- R12: After reset every thread is invalid, all counters are 0, and block_o, unblock_o and sqo_vld_o are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| asg_req_i | input | 1 | Assign request |
| asg_tid_i | input | TID_W | Thread of the assign request |
| asg_faulted_i | input | 1 | Instruction already faulted |
| asg_ok_o | output | 1 | Assign succeeded |
| asg_pc_o | output | PC_W | Instruction PC and fetch address |
| asg_seq_o | output | SEQ_W | Sequence number for the instruction |
| ctl_req_i | input | 1 | Control-update request |
| ctl_tid_i | input | TID_W | Thread of the control update |
| ctl_stage_i | input | STG_W | Requesting stage |
| ctl_faulted_i | input | 1 | Instruction already faulted |
| ctl_is_ctrl_i | input | 1 | Instruction is a control instruction |
| ctl_is_ret_i | input | 1 | Instruction is a return |
| ctl_pred_taken_i | input | 1 | Prediction was taken |
| block_o | output | NUM_THR*NUM_STG | Block pulses, bit tid*NUM_STG+stage |
| sqo_vld_o | output | 1 | Squash request out |
| sqo_tid_o | output | TID_W | Thread to squash |
| sqo_stage_o | output | STG_W | Stage the squash starts from |
| sq_vld_i | input | SQP | Incoming squash valid, per port |
| sq_tid_i | input | SQP*TID_W | Squash thread, per port |
| sq_seq_i | input | SQP*SEQ_W | Squash sequence number, per port |
| sq_fault_i | input | SQP | Squash caused by a fault, per port |
| sq_tgt_i | input | SQP*PC_W | Redirect target, per port |
| unblock_o | output | NUM_THR*NUM_STG | Unblock pulses, bit tid*NUM_STG+stage |
| act_vld_i | input | 1 | Activate thread |
| act_tid_i | input | TID_W | Thread to activate |
| trap_vld_i | input | 1 | Trap on thread |
| trap_tid_i | input | TID_W | Thread that trapped |
| arch_pc_i | input | PC_W | Architectural PC for activate or trap |
| deact_vld_i | input | 1 | Deactivate thread |
| deact_tid_i | input | TID_W | Thread to deactivate |

## Verification
The hardest situations to reach are those where two events meet in one cycle. Two squash ports can hit the same thread with ordered or reversed sequence numbers. A squash can land on the same thread as an assign request. An unblock must go to a stage recorded earlier, or reset by a deactivate. The bench first drives a table of assign requests across activated and inactive threads. Directed steps then build up each collision: a return is blocked at stage 2, a redirect follows, both ports fire in one cycle in each age order, and a deactivate precedes a redirect. Each outcome is checked through the next assign result or through the pulse bit that the stage decode must select.

// File: rtl/fps_pkg.sv
package fps_pkg;
   localparam int INST_BYTES = 4;

   typedef enum logic [1:0] {
      CTL_NONE   = 2'd0,
      CTL_BLOCK  = 2'd1,
      CTL_SQUASH = 2'd2
   } ctl_act_e;
endpackage

// File: rtl/fps_ctl_decode.sv
module fps_ctl_decode
   import fps_pkg::*;
(
   input  logic     req_i,
   input  logic     faulted_i,
   input  logic     is_ctrl_i,
   input  logic     is_ret_i,
   input  logic     pred_taken_i,
   output ctl_act_e act_o
);
   always_comb begin
      act_o = CTL_NONE;
      if (req_i && !faulted_i && is_ctrl_i) begin
         if (pred_taken_i)   act_o = CTL_SQUASH;
         else if (is_ret_i)  act_o = CTL_BLOCK;
      end
   end
endmodule

// File: rtl/fps_sq_arb.sv
module fps_sq_arb #(
   parameter int SQP   = 2,
   parameter int TID_W = 2,
   parameter int SEQ_W = 16
) (
   input  logic [SQP-1:0]       vld_i,
   input  logic [SQP*TID_W-1:0] tid_i,
   input  logic [SQP*SEQ_W-1:0] seq_i,
   output logic [SQP-1:0]       acc_o
);
   always_comb begin
      for (int p = 0; p < SQP; p++) begin
         acc_o[p] = vld_i[p];
         for (int q = 0; q < SQP; q++) begin
            if (q < p && acc_o[q]
                && tid_i[q*TID_W +: TID_W] == tid_i[p*TID_W +: TID_W]
                && seq_i[q*SEQ_W +: SEQ_W] <= seq_i[p*SEQ_W +: SEQ_W])
               acc_o[p] = 1'b0;
         end
      end
   end
endmodule

// File: rtl/fps_thread.sv
module fps_thread #(
   parameter int PC_W       = 32,
   parameter int SEQ_W      = 16,
   parameter int NUM_STG    = 5,
   parameter int STG_W      = 3,
   parameter int SQP        = 2,
   parameter int INST_BYTES = 4
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                adv_i,
   input  logic                blk_i,
   input  logic [STG_W-1:0]    blk_stage_i,
   input  logic                reload_i,
   input  logic [PC_W-1:0]     reload_pc_i,
   input  logic [SQP-1:0]      sq_hit_i,
   input  logic [SQP-1:0]      sq_fault_i,
   input  logic [SQP*PC_W-1:0] sq_tgt_i,
   input  logic                deact_i,
   output logic [PC_W-1:0]     pc_o,
   output logic [SEQ_W-1:0]    seq_o,
   output logic                valid_o,
   output logic [NUM_STG-1:0]  unblock_o
);
   logic [PC_W-1:0]    pc_q, pc_d;
   logic [SEQ_W-1:0]   seq_q, seq_d;
   logic               vld_q, vld_d;
   logic [STG_W-1:0]   stg_q, stg_d;
   logic [NUM_STG-1:0] ub_d;

   always_comb begin
      pc_d  = pc_q;
      seq_d = seq_q;
      vld_d = vld_q;
      stg_d = stg_q;
      ub_d  = '0;
      if (adv_i) begin
         pc_d  = pc_q + PC_W'(INST_BYTES);
         seq_d = seq_q + 1'b1;
      end
      if (blk_i) begin
         vld_d = 1'b0;
         stg_d = blk_stage_i;
      end
      if (reload_i) begin
         pc_d  = reload_pc_i;
         vld_d = 1'b1;
      end
      for (int p = 0; p < SQP; p++) begin
         if (sq_hit_i[p]) begin
            if (sq_fault_i[p]) begin
               vld_d = 1'b0;
            end else begin
               pc_d = sq_tgt_i[p*PC_W +: PC_W];
               if (!vld_d && 32'(stg_d) < NUM_STG) ub_d[stg_d] = 1'b1;
               vld_d = 1'b1;
            end
         end
      end
      if (deact_i) begin
         vld_d = 1'b0;
         stg_d = '0;
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         pc_q      <= '0;
         seq_q     <= '0;
         vld_q     <= 1'b0;
         stg_q     <= '0;
         unblock_o <= '0;
      end else begin
         pc_q      <= pc_d;
         seq_q     <= seq_d;
         vld_q     <= vld_d;
         stg_q     <= stg_d;
         unblock_o <= ub_d;
      end
   end

   assign pc_o    = pc_q;
   assign seq_o   = seq_q;
   assign valid_o = vld_q;
endmodule

// File: rtl/fetch_pc_seq.sv
module fetch_pc_seq
   import fps_pkg::*;
#(
   parameter int NUM_THR = 4,
   parameter int PC_W    = 32,
   parameter int SEQ_W   = 16,
   parameter int NUM_STG = 5,
   parameter int SQP     = 2,
   parameter int TID_W   = $clog2(NUM_THR),
   parameter int STG_W   = $clog2(NUM_STG)
) (
   input  logic                       clk,
   input  logic                       rst_n,
   input  logic                       asg_req_i,
   input  logic [TID_W-1:0]           asg_tid_i,
   input  logic                       asg_faulted_i,
   output logic                       asg_ok_o,
   output logic [PC_W-1:0]            asg_pc_o,
   output logic [SEQ_W-1:0]           asg_seq_o,
   input  logic                       ctl_req_i,
   input  logic [TID_W-1:0]           ctl_tid_i,
   input  logic [STG_W-1:0]           ctl_stage_i,
   input  logic                       ctl_faulted_i,
   input  logic                       ctl_is_ctrl_i,
   input  logic                       ctl_is_ret_i,
   input  logic                       ctl_pred_taken_i,
   output logic [NUM_THR*NUM_STG-1:0] block_o,
   output logic                       sqo_vld_o,
   output logic [TID_W-1:0]           sqo_tid_o,
   output logic [STG_W-1:0]           sqo_stage_o,
   input  logic [SQP-1:0]             sq_vld_i,
   input  logic [SQP*TID_W-1:0]       sq_tid_i,
   input  logic [SQP*SEQ_W-1:0]       sq_seq_i,
   input  logic [SQP-1:0]             sq_fault_i,
   input  logic [SQP*PC_W-1:0]        sq_tgt_i,
   output logic [NUM_THR*NUM_STG-1:0] unblock_o,
   input  logic                       act_vld_i,
   input  logic [TID_W-1:0]           act_tid_i,
   input  logic                       trap_vld_i,
   input  logic [TID_W-1:0]           trap_tid_i,
   input  logic [PC_W-1:0]            arch_pc_i,
   input  logic                       deact_vld_i,
   input  logic [TID_W-1:0]           deact_tid_i
);
   localparam int BLK_W = NUM_THR * NUM_STG;

   if (NUM_THR < 2)          begin : g_bad_thr $error("NUM_THR must be at least 2"); end
   if (SQP < 1)              begin : g_bad_sqp $error("SQP must be at least 1"); end
   if (NUM_STG > (1 << STG_W)) begin : g_bad_stg $error("STG_W too narrow"); end
   if (PC_W < 8)             begin : g_bad_pc  $error("PC_W too narrow"); end

   logic [PC_W-1:0]   pc_arr  [NUM_THR];
   logic [SEQ_W-1:0]  seq_arr [NUM_THR];
   logic [NUM_THR-1:0]         thr_valid;
   logic [NUM_THR*SEQ_W-1:0]   thr_seq_flat;
   logic [NUM_THR-1:0]         sq_any;
   logic [SQP-1:0]             sq_acc;
   ctl_act_e                   ctl_act;
   logic [BLK_W-1:0]           block_q;
   logic                       sqo_vld_q;
   logic [TID_W-1:0]           sqo_tid_q;
   logic [STG_W-1:0]           sqo_stage_q;

   fps_ctl_decode u_ctl (
      .req_i        (ctl_req_i),
      .faulted_i    (ctl_faulted_i),
      .is_ctrl_i    (ctl_is_ctrl_i),
      .is_ret_i     (ctl_is_ret_i),
      .pred_taken_i (ctl_pred_taken_i),
      .act_o        (ctl_act)
   );

   fps_sq_arb #(.SQP(SQP), .TID_W(TID_W), .SEQ_W(SEQ_W)) u_arb (
      .vld_i (sq_vld_i),
      .tid_i (sq_tid_i),
      .seq_i (sq_seq_i),
      .acc_o (sq_acc)
   );

   assign asg_pc_o  = pc_arr[asg_tid_i];
   assign asg_seq_o = seq_arr[asg_tid_i];
   assign asg_ok_o  = asg_req_i && !asg_faulted_i
                      && thr_valid[asg_tid_i] && !sq_any[asg_tid_i];

   for (genvar t = 0; t < NUM_THR; t++) begin : g_thr
      logic [SQP-1:0] hit;
      for (genvar p = 0; p < SQP; p++) begin : g_hit
         assign hit[p] = sq_acc[p] && (sq_tid_i[p*TID_W +: TID_W] == TID_W'(t));
      end
      assign sq_any[t] = |hit;

      fps_thread #(
         .PC_W(PC_W), .SEQ_W(SEQ_W), .NUM_STG(NUM_STG), .STG_W(STG_W),
         .SQP(SQP), .INST_BYTES(INST_BYTES)
      ) u_thr (
         .clk         (clk),
         .rst_n       (rst_n),
         .adv_i       (asg_ok_o && asg_tid_i == TID_W'(t)),
         .blk_i       (ctl_act == CTL_BLOCK && ctl_tid_i == TID_W'(t)),
         .blk_stage_i (ctl_stage_i),
         .reload_i    ((act_vld_i && act_tid_i == TID_W'(t))
                       || (trap_vld_i && trap_tid_i == TID_W'(t))),
         .reload_pc_i (arch_pc_i),
         .sq_hit_i    (hit),
         .sq_fault_i  (sq_fault_i),
         .sq_tgt_i    (sq_tgt_i),
         .deact_i     (deact_vld_i && deact_tid_i == TID_W'(t)),
         .pc_o        (pc_arr[t]),
         .seq_o       (seq_arr[t]),
         .valid_o     (thr_valid[t]),
         .unblock_o   (unblock_o[t*NUM_STG +: NUM_STG])
      );
      assign thr_seq_flat[t*SEQ_W +: SEQ_W] = seq_arr[t];
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         block_q     <= '0;
         sqo_vld_q   <= 1'b0;
         sqo_tid_q   <= '0;
         sqo_stage_q <= '0;
      end else begin
         block_q <= '0;
         if (ctl_act == CTL_BLOCK && 32'(ctl_stage_i) < NUM_STG)
            block_q[32'(ctl_tid_i) * NUM_STG + 32'(ctl_stage_i)] <= 1'b1;
         sqo_vld_q   <= (ctl_act == CTL_SQUASH);
         sqo_tid_q   <= ctl_tid_i;
         sqo_stage_q <= ctl_stage_i;
      end
   end

   assign block_o     = block_q;
   assign sqo_vld_o   = sqo_vld_q;
   assign sqo_tid_o   = sqo_tid_q;
   assign sqo_stage_o = sqo_stage_q;
endmodule

// File: rtl/fps_checker.sv
module fps_checker #(
   parameter int NUM_THR = 4,
   parameter int SEQ_W   = 16,
   parameter int NUM_STG = 5,
   parameter int TID_W   = 2
) (
   input logic                       clk,
   input logic                       rst_n,
   input logic                       asg_req_i,
   input logic [TID_W-1:0]           asg_tid_i,
   input logic                       asg_faulted_i,
   input logic                       asg_ok_o,
   input logic [SEQ_W-1:0]           asg_seq_o,
   input logic [NUM_THR-1:0]         thr_valid,
   input logic [NUM_THR*SEQ_W-1:0]   thr_seq_flat,
   input logic [NUM_THR*NUM_STG-1:0] block_o,
   input logic                       sqo_vld_o,
   input logic                       ctl_req_i,
   input logic                       ctl_faulted_i,
   input logic                       ctl_is_ctrl_i,
   input logic                       ctl_pred_taken_i
);
   logic             prev_ok;
   logic [TID_W-1:0] prev_tid;
   logic [SEQ_W-1:0] prev_seq;
   logic [SEQ_W-1:0] seq_now;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         prev_ok  <= 1'b0;
         prev_tid <= '0;
         prev_seq <= '0;
      end else begin
         prev_ok  <= asg_ok_o;
         prev_tid <= asg_tid_i;
         prev_seq <= asg_seq_o;
      end
   end

   assign seq_now = thr_seq_flat[32'(prev_tid)*SEQ_W +: SEQ_W];

   a_r2_seq_step: assert property (@(posedge clk) disable iff (!rst_n)
      prev_ok |-> seq_now == prev_seq + 1'b1);

   a_r3_ok_needs_valid: assert property (@(posedge clk) disable iff (!rst_n)
      asg_ok_o |-> thr_valid[asg_tid_i]);

   a_r4_faulted_no_ok: assert property (@(posedge clk) disable iff (!rst_n)
      (asg_req_i && asg_faulted_i) |-> !asg_ok_o);

   a_r5_block_onehot: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(block_o));

   a_r6_sqo_cause: assert property (@(posedge clk) disable iff (!rst_n)
      sqo_vld_o |-> $past(ctl_req_i && !ctl_faulted_i && ctl_is_ctrl_i && ctl_pred_taken_i));
endmodule

bind fetch_pc_seq fps_checker #(
   .NUM_THR(NUM_THR), .SEQ_W(SEQ_W), .NUM_STG(NUM_STG), .TID_W(TID_W)
) u_fps_chk (
   .clk              (clk),
   .rst_n            (rst_n),
   .asg_req_i        (asg_req_i),
   .asg_tid_i        (asg_tid_i),
   .asg_faulted_i    (asg_faulted_i),
   .asg_ok_o         (asg_ok_o),
   .asg_seq_o        (asg_seq_o),
   .thr_valid        (thr_valid),
   .thr_seq_flat     (thr_seq_flat),
   .block_o          (block_o),
   .sqo_vld_o        (sqo_vld_o),
   .ctl_req_i        (ctl_req_i),
   .ctl_faulted_i    (ctl_faulted_i),
   .ctl_is_ctrl_i    (ctl_is_ctrl_i),
   .ctl_pred_taken_i (ctl_pred_taken_i)
);

// File: tb/tb_fetch_pc_seq.sv
`timescale 1ns/1ps
module tb_fetch_pc_seq;
   localparam int NT = 4, PCW = 32, SW = 16, NS = 5, SQP = 2, TW = 2, STW = 3;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   always #4 clk = ~clk;

   logic asg_req, asg_faulted, asg_ok;
   logic [TW-1:0] asg_tid;
   logic [PCW-1:0] asg_pc;
   logic [SW-1:0] asg_seq;
   logic ctl_req, ctl_faulted, ctl_is_ctrl, ctl_is_ret, ctl_pred_taken;
   logic [TW-1:0] ctl_tid;
   logic [STW-1:0] ctl_stage;
   logic [NT*NS-1:0] block, unblock;
   logic sqo_vld;
   logic [TW-1:0] sqo_tid;
   logic [STW-1:0] sqo_stage;
   logic [SQP-1:0] sq_vld, sq_fault;
   logic [SQP*TW-1:0] sq_tid;
   logic [SQP*SW-1:0] sq_seq;
   logic [SQP*PCW-1:0] sq_tgt;
   logic act_vld, trap_vld, deact_vld;
   logic [TW-1:0] act_tid, trap_tid, deact_tid;
   logic [PCW-1:0] arch_pc;

   fetch_pc_seq dut (
      .clk(clk), .rst_n(rst_n),
      .asg_req_i(asg_req), .asg_tid_i(asg_tid), .asg_faulted_i(asg_faulted),
      .asg_ok_o(asg_ok), .asg_pc_o(asg_pc), .asg_seq_o(asg_seq),
      .ctl_req_i(ctl_req), .ctl_tid_i(ctl_tid), .ctl_stage_i(ctl_stage),
      .ctl_faulted_i(ctl_faulted), .ctl_is_ctrl_i(ctl_is_ctrl),
      .ctl_is_ret_i(ctl_is_ret), .ctl_pred_taken_i(ctl_pred_taken),
      .block_o(block), .sqo_vld_o(sqo_vld), .sqo_tid_o(sqo_tid), .sqo_stage_o(sqo_stage),
      .sq_vld_i(sq_vld), .sq_tid_i(sq_tid), .sq_seq_i(sq_seq), .sq_fault_i(sq_fault),
      .sq_tgt_i(sq_tgt), .unblock_o(unblock),
      .act_vld_i(act_vld), .act_tid_i(act_tid), .trap_vld_i(trap_vld), .trap_tid_i(trap_tid),
      .arch_pc_i(arch_pc), .deact_vld_i(deact_vld), .deact_tid_i(deact_tid)
   );

   int n_vec = 0;
   int n_bad = 0;
   bit finished = 1'b0;

   // {tid[8], ok[8], pc[32], seq[16]}
   localparam logic [63:0] VEC [8] = '{
      {8'd0, 8'd1, 32'h1000, 16'd0},
      {8'd0, 8'd1, 32'h1004, 16'd1},
      {8'd1, 8'd1, 32'h2000, 16'd0},
      {8'd2, 8'd0, 32'h0,    16'd0},
      {8'd0, 8'd1, 32'h1008, 16'd2},
      {8'd1, 8'd1, 32'h2004, 16'd1},
      {8'd3, 8'd0, 32'h0,    16'd0},
      {8'd1, 8'd1, 32'h2008, 16'd2}
   };

   task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
      n_vec++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
      end
   endtask

   task automatic idle();
      asg_req = 0; asg_tid = 0; asg_faulted = 0;
      ctl_req = 0; ctl_tid = 0; ctl_stage = 0; ctl_faulted = 0;
      ctl_is_ctrl = 0; ctl_is_ret = 0; ctl_pred_taken = 0;
      sq_vld = 0; sq_tid = 0; sq_seq = 0; sq_fault = 0; sq_tgt = 0;
      act_vld = 0; act_tid = 0; trap_vld = 0; trap_tid = 0; arch_pc = 0;
      deact_vld = 0; deact_tid = 0;
   endtask

   task automatic tick();
      @(posedge clk); #2;
      idle();
   endtask

   task automatic assign_chk(input string tag, input int tid, input bit ok,
                             input logic [31:0] pc, input logic [15:0] seq);
      asg_req = 1; asg_tid = TW'(tid);
      #1;
      chk({tag, " ok"}, 64'(asg_ok), 64'(ok));
      if (ok) begin
         chk({tag, " pc"}, 64'(asg_pc), 64'(pc));
         chk({tag, " seq"}, 64'(asg_seq), 64'(seq));
      end
      tick();
   endtask

   task automatic squash(input int port, input int tid, input int seq,
                         input bit fault, input logic [31:0] tgt);
      sq_vld[port] = 1;
      sq_tid[port*TW +: TW] = TW'(tid);
      sq_seq[port*SW +: SW] = SW'(seq);
      sq_fault[port] = fault;
      sq_tgt[port*PCW +: PCW] = tgt;
   endtask

   task automatic report();
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
   endtask

   initial begin
      repeat (20000) @(posedge clk);
      if (!finished) begin
         n_bad++;
         $display("FAIL watchdog: actual timeout expected completion");
         report();
         $finish;
      end
   end

   initial begin
      idle();
      repeat (3) @(posedge clk);
      #2 rst_n = 1;
      // R12 reset state
      chk("R12 block", 64'(block), 64'd0);
      chk("R12 unblock", 64'(unblock), 64'd0);
      chk("R12 sqo", 64'(sqo_vld), 64'd0);
      assign_chk("R12 invalid t0", 0, 0, 0, 0);

      // R10 activate
      act_vld = 1; act_tid = 0; arch_pc = 32'h1000; tick();
      act_vld = 1; act_tid = 1; arch_pc = 32'h2000; tick();

      // R1 R2 R3 vector table
      for (int i = 0; i < 8; i++) begin
         assign_chk($sformatf("R1/R2/R3 vec%0d", i), int'(VEC[i][63:56]),
                    VEC[i][48], VEC[i][47:16], VEC[i][15:0]);
      end

      // R4 faulted assign
      asg_req = 1; asg_tid = 0; asg_faulted = 1; #1;
      chk("R4 faulted assign", 64'(asg_ok), 64'd0);
      tick();
      assign_chk("R4 after fault", 0, 1, 32'h100C, 16'd3);

      // R4 faulted control update
      ctl_req = 1; ctl_tid = 0; ctl_stage = 1; ctl_faulted = 1;
      ctl_is_ctrl = 1; ctl_is_ret = 1; tick();
      chk("R4 faulted ctl block", 64'(block), 64'd0);
      assign_chk("R4 faulted ctl keeps valid", 0, 1, 32'h1010, 16'd4);

      // R6 non-control ignored
      ctl_req = 1; ctl_tid = 0; ctl_stage = 2; ctl_pred_taken = 1; tick();
      chk("R6 nonctrl sqo", 64'(sqo_vld), 64'd0);
      chk("R6 nonctrl block", 64'(block), 64'd0);

      // R6 taken control
      ctl_req = 1; ctl_tid = 1; ctl_stage = 3; ctl_is_ctrl = 1; ctl_pred_taken = 1; tick();
      chk("R6 sqo vld", 64'(sqo_vld), 64'd1);
      chk("R6 sqo tid", 64'(sqo_tid), 64'd1);
      chk("R6 sqo stage", 64'(sqo_stage), 64'd3);
      tick();
      chk("R6 sqo single", 64'(sqo_vld), 64'd0);

      // R5 return not-taken blocks
      ctl_req = 1; ctl_tid = 1; ctl_stage = 2; ctl_is_ctrl = 1; ctl_is_ret = 1; tick();
      chk("R5 block bit", 64'(block), 64'(1) << 7);
      assign_chk("R5 stalled", 1, 0, 0, 0);
      chk("R5 block single", 64'(block), 64'd0);

      // R8 redirect unblocks recorded stage
      squash(0, 1, 10, 0, 32'h3000); tick();
      chk("R8 unblock bit", 64'(unblock), 64'(1) << 7);
      assign_chk("R8 redirect pc", 1, 1, 32'h3000, 16'd3);
      squash(0, 1, 11, 0, 32'h3100); tick();
      chk("R8 no unblock when valid", 64'(unblock), 64'd0);
      assign_chk("R8 redirect valid", 1, 1, 32'h3100, 16'd4);

      // R7 arbitration
      squash(0, 0, 5, 0, 32'h4000); squash(1, 0, 7, 0, 32'h4400); tick();
      assign_chk("R7 younger dropped", 0, 1, 32'h4000, 16'd5);
      squash(0, 0, 9, 0, 32'h4800); squash(1, 0, 4, 0, 32'h4C00); tick();
      assign_chk("R7 older wins", 0, 1, 32'h4C00, 16'd6);
      squash(0, 0, 3, 0, 32'h5000); squash(1, 1, 8, 0, 32'h5400); tick();
      assign_chk("R7 split t0", 0, 1, 32'h5000, 16'd7);
      assign_chk("R7 split t1", 1, 1, 32'h5400, 16'd5);

      // R11 squash beats assign
      asg_req = 1; asg_tid = 0; squash(0, 0, 2, 0, 32'h6000); #1;
      chk("R11 assign blocked", 64'(asg_ok), 64'd0);
      tick();
      assign_chk("R11 seq kept", 0, 1, 32'h6000, 16'd8);

      // R8 faulting squash
      squash(0, 0, 1, 1, 32'hDEAD); tick();
      chk("R8 fault no unblock", 64'(unblock), 64'd0);
      assign_chk("R8 fault invalid", 0, 0, 0, 0);

      // R10 trap
      trap_vld = 1; trap_tid = 0; arch_pc = 32'h7000; tick();
      assign_chk("R10 trap pc", 0, 1, 32'h7000, 16'd9);

      // R9 deactivate
      deact_vld = 1; deact_tid = 1; tick();
      assign_chk("R9 deact stall", 1, 0, 0, 0);
      squash(0, 1, 1, 0, 32'h8000); tick();
      chk("R9 stage reset", 64'(unblock), 64'(1) << 5);
      assign_chk("R9 redirect after deact", 1, 1, 32'h8000, 16'd6);

      // R10 activate fresh thread
      act_vld = 1; act_tid = 2; arch_pc = 32'h9000; tick();
      assign_chk("R10 activate t2", 2, 1, 32'h9000, 16'd0);

      finished = 1'b1;
      report();
      $finish;
   end
endmodule